// File: doc/BRIEF.md
# NAND Page Hamming ECC

This block computes and checks a single-error-correcting, double-error-detecting code for NAND flash pages. It sits on the byte stream between the controller and the flash device. For every 256-byte chunk it gathers two 11-bit parity words. The first word is the XOR of the bit addresses of all data bits that read as one. The second word is the XOR of the bitwise complements of those addresses. A page can be 256 or 512 bytes long. A 512-byte page yields a second code that covers its upper chunk.

The check side takes a code stored with the page and a code freshly computed from the data read back. It XORs them into a syndrome and sorts the result into four classes:

- clean
- single data-bit error, reported with its byte and bit location
- error in the stored code itself
- uncorrectable

Software or a DMA engine applies any fix.

Top module: `nand_page_ecc`

## Requirements
- R1: After reset, `code0` and `code1` are zero and `res_vld` is low.
- R2: `clr` zeroes both codes and restarts the byte index at 0 on the next edge. It wins over a `dat_vld` asserted in the same cycle, and that byte is dropped.
- R3: Each accepted byte at index k (counted from 0 since the last `clr`) contributes per data bit b that is 1 the 11-bit address a = k*8 + b. `code0[10:0]` is the XOR of all such a and `code0[21:11]` is the XOR of all ~a.
- R4: With `page512`=1, bytes 0..255 update `code0` and bytes 256..511 update `code1`, the latter using the index k-256 in their addresses.
- R5: Bytes beyond the page length (256 with `page512`=0, 512 with `page512`=1) are ignored. With `page512`=0 `code1` never changes except by `clr`.
- R6: `res_vld` pulses high for exactly the one cycle after a cycle with `chk_vld` high, and stays low otherwise.
- R7: With syndrome s = `stored_code` ^ `calc_code`, if s is zero or either code is zero, `res_status` = 0 (clean).
- R8: Otherwise, if exactly one bit of s is set, `res_status` = 2 (stored code damaged).
- R9: Otherwise, if s has eleven ones and s[10:0] ^ s[21:11] = 0x7FF, `res_status` = 1 (correctable). `res_byte` = s[10:3] and `res_bit` = s[2:0]. For all other results both location fields are zero.
- R10: Every remaining syndrome gives `res_status` = 3 (uncorrectable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Page start: clear codes and byte index |
| page512 | input | 1 | 1 = 512-byte page, 0 = 256-byte page |
| dat_vld | input | 1 | Byte on `dat` is transferred this cycle |
| dat | input | 8 | Page data byte |
| code0 | output | 22 | Code of bytes 0..255 |
| code1 | output | 22 | Code of bytes 256..511 |
| chk_vld | input | 1 | Compare `stored_code` with `calc_code` |
| stored_code | input | 22 | Code read from the spare area |
| calc_code | input | 22 | Code computed from read data |
| res_vld | output | 1 | Result pulse |
| res_status | output | 2 | 0 clean, 1 corrected, 2 code error, 3 uncorrectable |
| res_byte | output | 8 | Failing byte index within the chunk |
| res_bit | output | 3 | Failing bit within the byte |

## Verification
A byte presented in one cycle is folded into the codes at that clock edge. The bench therefore drives data at falling edges and reads the codes at the falling edge that follows the last byte. A `clr` pulse shows as zero codes one edge later. A compare request shows its classification and the `res_vld` pulse one edge after `chk_vld`, and the bench samples there. It then checks at the next falling edge that the pulse has already dropped.

// File: rtl/nand_page_ecc.sv
module nand_page_ecc #(
  parameter int CHUNK_LOG2 = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          page512,
  input  logic                          dat_vld,
  input  logic [7:0]                    dat,
  output logic [2*(CHUNK_LOG2+3)-1:0]   code0,
  output logic [2*(CHUNK_LOG2+3)-1:0]   code1,
  input  logic                          chk_vld,
  input  logic [2*(CHUNK_LOG2+3)-1:0]   stored_code,
  input  logic [2*(CHUNK_LOG2+3)-1:0]   calc_code,
  output logic                          res_vld,
  output logic [1:0]                    res_status,
  output logic [CHUNK_LOG2-1:0]         res_byte,
  output logic [2:0]                    res_bit
);
  localparam int PW = CHUNK_LOG2 + 3;
  localparam int CW = 2 * PW;
  localparam int NW = CHUNK_LOG2 + 2;
  localparam logic [NW-1:0] LIM1 = NW'(1) << CHUNK_LOG2;
  localparam logic [NW-1:0] LIM2 = NW'(1) << (CHUNK_LOG2 + 1);

  logic [NW-1:0] cnt;
  logic [PW-1:0] p0a, p0b, p1a, p1b;
  logic [PW-1:0] bp, bn;

  wire [NW-1:0] limit = page512 ? LIM2 : LIM1;
  wire          take  = dat_vld && (cnt < limit);
  wire          upper = cnt[CHUNK_LOG2];

  always_comb begin
    bp = '0;
    bn = '0;
    for (int b = 0; b < 8; b++) begin
      if (dat[b]) begin
        bp = bp ^ {cnt[CHUNK_LOG2-1:0], 3'(b)};
        bn = bn ^ ~{cnt[CHUNK_LOG2-1:0], 3'(b)};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      p0a <= '0; p0b <= '0; p1a <= '0; p1b <= '0;
    end else if (clr) begin
      cnt <= '0;
      p0a <= '0; p0b <= '0; p1a <= '0; p1b <= '0;
    end else if (take) begin
      cnt <= cnt + 1'b1;
      if (upper) begin
        p1a <= p1a ^ bp;
        p1b <= p1b ^ bn;
      end else begin
        p0a <= p0a ^ bp;
        p0b <= p0b ^ bn;
      end
    end
  end

  assign code0 = {p0b, p0a};
  assign code1 = {p1b, p1a};

  wire [CW-1:0] syn = stored_code ^ calc_code;

  function automatic int ones(input logic [CW-1:0] v);
    int n = 0;
    for (int i = 0; i < CW; i++) n += int'(v[i]);
    return n;
  endfunction

  logic [1:0] st_d;
  always_comb begin
    if (syn == '0 || stored_code == '0 || calc_code == '0)
      st_d = 2'd0;
    else if (ones(syn) == 1)
      st_d = 2'd2;
    else if (ones(syn) == PW && (syn[PW-1:0] ^ syn[CW-1:PW]) == '1)
      st_d = 2'd1;
    else
      st_d = 2'd3;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld    <= 1'b0;
      res_status <= 2'd0;
      res_byte   <= '0;
      res_bit    <= '0;
    end else begin
      res_vld <= chk_vld;
      if (chk_vld) begin
        res_status <= st_d;
        res_byte   <= (st_d == 2'd1) ? syn[PW-1:3] : '0;
        res_bit    <= (st_d == 2'd1) ? syn[2:0] : '0;
      end
    end
  end
endmodule

// File: rtl/nand_page_ecc_props.sv
module nand_page_ecc_props #(
  parameter int CHUNK_LOG2 = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        clr,
  input logic                        page512,
  input logic                        dat_vld,
  input logic [7:0]                  dat,
  input logic [2*(CHUNK_LOG2+3)-1:0] code0,
  input logic [2*(CHUNK_LOG2+3)-1:0] code1,
  input logic                        chk_vld,
  input logic [2*(CHUNK_LOG2+3)-1:0] stored_code,
  input logic [2*(CHUNK_LOG2+3)-1:0] calc_code,
  input logic                        res_vld,
  input logic [1:0]                  res_status,
  input logic [CHUNK_LOG2-1:0]       res_byte,
  input logic [2:0]                  res_bit
);
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (code0 == '0 && code1 == '0)); // R2
  AST_CODE1_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!page512 && !clr) |=> $stable(code1)); // R5
  AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n) chk_vld |=> res_vld); // R6
  AST_RES_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !chk_vld |=> !res_vld); // R6
  AST_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_vld && (stored_code == calc_code || stored_code == '0 || calc_code == '0)) |=> res_status == 2'd0); // R7
  AST_CODE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_vld && stored_code != '0 && calc_code != '0 && $countones(stored_code ^ calc_code) == 1) |=> res_status == 2'd2); // R8
  AST_LOC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_status != 2'd1) |-> (res_byte == '0 && res_bit == '0)); // R9
  AST_MANY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_vld && stored_code != '0 && calc_code != '0 && $countones(stored_code ^ calc_code) > CHUNK_LOG2 + 3) |=> res_status == 2'd3); // R10
endmodule

bind nand_page_ecc nand_page_ecc_props #(.CHUNK_LOG2(CHUNK_LOG2)) u_props (.*);

// File: tb/sim_nand_page_ecc.sv
`timescale 1ns/1ps
module sim_nand_page_ecc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, page512 = 1'b0, dat_vld = 1'b0, chk_vld = 1'b0;
  logic [7:0] dat = '0;
  logic [21:0] code0, code1, stored_code = '0, calc_code = '0;
  logic res_vld;
  logic [1:0] res_status;
  logic [7:0] res_byte;
  logic [2:0] res_bit;

  int checks = 0, fails = 0, mcnt = 0;
  logic [21:0] e0 = '0, e1 = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nand_page_ecc u0 (.*);

  function automatic logic [21:0] bpar(input logic [7:0] v, input int k);
    logic [10:0] a, p = '0, n = '0;
    for (int b = 0; b < 8; b++) begin
      a = 11'(k * 8 + b);
      if (v[b]) begin p ^= a; n ^= ~a; end
    end
    return {n, p};
  endfunction

  function automatic logic [21:0] synof(input int addr);
    logic [10:0] a = 11'(addr);
    return {~a, a};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 code0", 32'(code0), 0);
    chk("R1 code1", 32'(code1), 0);
    chk("R1 res_vld", 32'(res_vld), 0);
  endtask

  task automatic t_clr(input bit with_data);
    @(negedge clk);
    clr = 1'b1; dat_vld = with_data; dat = 8'hFF;
    @(negedge clk);
    clr = 1'b0; dat_vld = 1'b0;
    e0 = '0; e1 = '0; mcnt = 0;
    chk("R2 code0 cleared", 32'(code0), 0);
    chk("R2 code1 cleared", 32'(code1), 0);
  endtask

  task automatic t_feed(input int n, input int seed, input bit p512);
    int lim = p512 ? 512 : 256;
    page512 = p512;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dat_vld = 1'b1;
      dat = 8'((i * 37 + seed) & 255);
      if (mcnt < lim) begin
        if (mcnt < 256) e0 ^= bpar(dat, mcnt);
        else            e1 ^= bpar(dat, mcnt - 256);
        mcnt++;
      end
    end
    @(negedge clk);
    dat_vld = 1'b0;
  endtask

  task automatic t_cmp(input logic [21:0] s, input logic [21:0] c,
                       input int st, input int by, input int bi, input string req);
    @(negedge clk);
    stored_code = s; calc_code = c; chk_vld = 1'b1;
    @(negedge clk);
    chk_vld = 1'b0;
    chk({req, " res_vld"}, 32'(res_vld), 1);
    chk({req, " status"}, 32'(res_status), 32'(st));
    chk({req, " byte"}, 32'(res_byte), 32'(by));
    chk({req, " bit"}, 32'(res_bit), 32'(bi));
    @(negedge clk);
    chk("R6 pulse ends", 32'(res_vld), 0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [21:0] base;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();

    // R3: one byte 0x01 at index 0 gives low word 0, high word all ones
    t_clr(0);
    t_feed(1, 1, 0);
    chk("R3 single bit at address 0", 32'(code0), 32'(22'h3FF800));

    // R3 R5: full 256-byte page, then surplus bytes
    t_clr(0);
    t_feed(256, 5, 0);
    chk("R3 page code0", 32'(code0), 32'(e0));
    chk("R5 code1 untouched", 32'(code1), 0);
    t_feed(12, 99, 0);
    chk("R5 surplus ignored code0", 32'(code0), 32'(e0));
    chk("R5 surplus ignored code1", 32'(code1), 0);

    // R2: clr beats data in the same cycle
    t_clr(1);
    t_feed(3, 17, 0);
    chk("R2 index restarts", 32'(code0), 32'(e0));

    // R4: 512-byte page with surplus
    t_clr(0);
    t_feed(520, 11, 1);
    chk("R4 code0 lower chunk", 32'(code0), 32'(e0));
    chk("R4 code1 upper chunk", 32'(code1), 32'(e1));
    page512 = 1'b0;

    base = e0;
    t_cmp(base, base, 0, 0, 0, "R7 equal");
    t_cmp(22'h0, base ^ synof(5), 0, 0, 0, "R7 stored zero");
    t_cmp(base, base ^ 22'h000400, 2, 0, 0, "R8 code bit");
    t_cmp(base, base ^ synof(77 * 8 + 5), 1, 77, 5, "R9 data bit");
    t_cmp(base, base ^ synof(255 * 8 + 7), 1, 255, 7, "R9 last bit");
    t_cmp(base, base ^ synof(3) ^ synof(900), 3, 0, 0, "R10 two bits");
    t_cmp(base, base ^ 22'h000003, 3, 0, 0, "R10 two code bits");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule